// File: doc/BRIEF.md
# Shared-Memory Circular Queue Manager

This block keeps a parameterized set of word FIFOs (eight by default) inside one shared, word-addressed memory. Each queue is a circular region whose position and length come from a packed configuration word. The host reaches everything over a simple single-beat bus. A write to a queue's access address pushes a word and a read from it pops one. Other address regions hold the configuration words, the packed fill-status words and a word of sticky error bits.

The block does not stall when a queue is misused. A pop from an empty queue returns zero and sets a sticky underflow bit. A push to a full queue is dropped and sets a sticky overflow bit. For every queue the block produces a 4-bit fill status (empty, nearly empty, nearly full, full). These nibbles go straight out on a port to a separate interrupt block. Both watermarks are programmable per queue.

The bus address is split into a region in `addr_i[11:8]` and an index in `addr_i[7:0]`. The regions are: 0 for queue access, 1 for configuration, 2 for status words and 3 for sticky error words.

Top module: `shq_manager`

## Requirements
- R1: After reset, every configuration word, every pointer and every sticky bit reads zero. Each queue's status nibble reads 4'h3 (empty and nearly empty), and `rvalid_o` is low until a read is issued.
- R2: Queues are first-in first-out. Every bus read (req_i=1, we_i=0) produces `rvalid_o` high for exactly one cycle on the next cycle, with its data on `rdata_o` in that same cycle. Writes produce no `rvalid_o`.
- R3: A pop from an empty queue returns 0 and sets bit 2*q of the sticky error word (region 3, index 0).
- R4: A push to a full queue is discarded, so the stored contents stay intact, and it sets bit 2*q+1 of the sticky error word.
- R5: Writing the sticky error word clears each bit written as 0 and leaves each bit written as 1 unchanged. A set bit stays set until it is cleared this way.
- R6: Configuration word layout: write pointer [6:0], read pointer [13:7], entry-size code [15:14], buffer-size code [17:16], nearly-empty code [20:18], nearly-full code [23:21], base in 16-word units [31:24]. The pointers count modulo 128, so a full 128-entry queue reads equal pointers.
- R7: Buffer-size codes 0..3 give 16, 32, 64 and 128 entries. Entry p of a queue lives at memory word base*16 + (p mod size). Indices wrap inside the region, and queues placed in disjoint regions do not disturb each other.
- R8: Watermark codes: 0 means 0, and codes 1..7 mean 1, 2, 4, 8, 16, 32 and 64. The nearly-empty flag is set when occupancy <= the nearly-empty value.
- R9: The nearly-full flag is set when (size - occupancy) <= the nearly-full value.
- R10: Status nibble: bit0 empty, bit1 nearly empty, bit2 nearly full, bit3 full. Queue q's nibble sits at bits 4*(q mod 8)+3..4*(q mod 8) of status word q/8 (region 2) and at the same position in `q_status_o`.
- R11: Writing a configuration word empties that queue: both pointers return to 0 and its next pop underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write/push, 0 = read/pop |
| addr_i | input | AW (12) | Region [11:8], index [7:0] |
| wdata_i | input | DW (32) | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| rdata_o | output | DW (32) | Read data |
| q_status_o | output | 4*NQ (32) | Fill-status nibbles of all queues |

## Verification
The bench targets the fill boundaries. It pushes exactly to capacity and one past it: a design that advanced its pointer on the dropped push would hand back a corrupted first entry. It fills a 128-entry queue, where both pointers wrap back to equal values; a design that derived occupancy only from the pointer difference would report that queue empty. It walks every occupancy of a 32-entry queue to place both watermark thresholds exactly, since an off-by-one comparison shows up at one step only. It also crosses the circular wrap, rewrites a live configuration, and clears sticky bits selectively, so a design that cleared all bits on any write would lose a neighbouring queue's error.

// File: rtl/shq_pkg.sv
package shq_pkg;
  localparam int PTR_W = 7;

  localparam int RG_ACC  = 0;
  localparam int RG_CFG  = 1;
  localparam int RG_STAT = 2;
  localparam int RG_UO   = 3;

  typedef struct packed {
    logic [7:0] base;  // 16-word units
    logic [2:0] nf;
    logic [2:0] ne;
    logic [1:0] bsz;
    logic [1:0] esz;
  } shq_cfg_t;

  function automatic logic [7:0] wm_value(input logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

  function automatic logic [7:0] buf_words(input logic [1:0] code);
    return 8'd16 << code;
  endfunction
endpackage

// File: rtl/shq_sram.sv
module shq_sram #(
  parameter int WORDS = 512,
  parameter int DW    = 32,
  localparam int SAW  = $clog2(WORDS)
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [SAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    else if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/shq_slot.sv
module shq_slot
  import shq_pkg::*;
#(
  parameter int SAW = 9,
  parameter int DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  shq_cfg_t       cfg_i,
  input  logic           push_i,
  input  logic           pop_i,
  output logic [DW-1:0]  cfg_o,
  output logic [3:0]     stat_o,
  output logic [SAW-1:0] wr_addr_o,
  output logic [SAW-1:0] rd_addr_o
);
  shq_cfg_t         cfg_q;
  logic [PTR_W-1:0] wptr_q, rptr_q, mask;
  logic [7:0]       occ_q, size, free, ne_v, nf_v;
  logic [11:0]      wa, ra;

  // occupancy kept apart from pointers: a 128-entry queue full has equal pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else if (cfg_we_i) begin
      cfg_q  <= cfg_i;
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 7'd1;
      if (pop_i)  rptr_q <= rptr_q + 7'd1;
      case ({push_i, pop_i})
        2'b10:   occ_q <= occ_q + 8'd1;
        2'b01:   occ_q <= occ_q - 8'd1;
        default: ;
      endcase
    end
  end

  assign size = buf_words(cfg_q.bsz);
  assign mask = size[PTR_W-1:0] - 7'd1;
  assign free = size - occ_q;
  assign ne_v = wm_value(cfg_q.ne);
  assign nf_v = wm_value(cfg_q.nf);

  assign wa = {cfg_q.base, 4'b0000} + {5'b00000, wptr_q & mask};
  assign ra = {cfg_q.base, 4'b0000} + {5'b00000, rptr_q & mask};
  assign wr_addr_o = wa[SAW-1:0];
  assign rd_addr_o = ra[SAW-1:0];

  assign stat_o = {occ_q == size, free <= nf_v, occ_q <= ne_v, occ_q == 8'd0};
  assign cfg_o  = DW'({cfg_q, rptr_q, wptr_q});
endmodule

// File: rtl/shq_manager.sv
module shq_manager
  import shq_pkg::*;
#(
  parameter int NQ         = 8,
  parameter int SRAM_WORDS = 512,
  parameter int AW         = 12,
  parameter int DW         = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            rvalid_o,
  output logic [DW-1:0]   rdata_o,
  output logic [4*NQ-1:0] q_status_o
);
  localparam int SAW  = $clog2(SRAM_WORDS);
  localparam int QIW  = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int SPW  = DW / 4;
  localparam int UPW  = DW / 2;
  localparam int NSW  = (NQ + SPW - 1) / SPW;
  localparam int NUW  = (NQ + UPW - 1) / UPW;

  logic [AW-9:0]  region;
  logic [7:0]     idx;
  logic [QIW-1:0] qsel;
  logic           hit, acc, push_req, pop_req, full_sel, empty_sel, push_ok, pop_ok;
  logic           cfg_wr, uo_wr;

  logic [DW-1:0]  cfg_rd [NQ];
  logic [3:0]     st [NQ];
  logic [SAW-1:0] wa [NQ];
  logic [SAW-1:0] ra [NQ];

  logic [2*NQ-1:0]   uo_q, uo_d;
  logic [NSW*DW-1:0] stat_pad;
  logic [NUW*DW-1:0] uo_pad, uo_keep;

  logic           rvalid_q, from_sram_q;
  logic [DW-1:0]  rreg_q, rd_mux, sram_rd;

  assign region   = addr_i[AW-1:8];
  assign idx      = addr_i[7:0];
  assign qsel     = idx[QIW-1:0];
  assign hit      = int'(idx) < NQ;
  assign acc      = req_i && (int'(region) == RG_ACC) && hit;
  assign push_req = acc && we_i;
  assign pop_req  = acc && !we_i;
  assign full_sel  = st[qsel][3];
  assign empty_sel = st[qsel][0];
  assign push_ok  = push_req && !full_sel;
  assign pop_ok   = pop_req && !empty_sel;
  assign cfg_wr   = req_i && we_i && (int'(region) == RG_CFG) && hit;
  assign uo_wr    = req_i && we_i && (int'(region) == RG_UO) && (int'(idx) < NUW);

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    shq_slot #(.SAW(SAW), .DW(DW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (cfg_wr && (qsel == QIW'(g))),
      .cfg_i     (shq_cfg_t'(wdata_i[31:14])),
      .push_i    (push_ok && (qsel == QIW'(g))),
      .pop_i     (pop_ok && (qsel == QIW'(g))),
      .cfg_o     (cfg_rd[g]),
      .stat_o    (st[g]),
      .wr_addr_o (wa[g]),
      .rd_addr_o (ra[g])
    );
    assign q_status_o[4*g +: 4] = st[g];
  end

  shq_sram #(.WORDS(SRAM_WORDS), .DW(DW)) u_sram (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .re_i    (pop_ok),
    .addr_i  (push_ok ? wa[qsel] : ra[qsel]),
    .wdata_i (wdata_i),
    .rdata_o (sram_rd)
  );

  always_comb begin
    stat_pad = '0;
    stat_pad[4*NQ-1:0] = q_status_o;
    uo_pad = '0;
    uo_pad[2*NQ-1:0] = uo_q;
    uo_keep = '1;
    if (uo_wr) uo_keep[int'(idx)*DW +: DW] = wdata_i;
  end

  // sticky error bits: write-0-to-clear, set by misuse
  always_comb begin
    uo_d = uo_q & uo_keep[2*NQ-1:0];
    if (pop_req && empty_sel) uo_d[2*int'(qsel)]     = 1'b1;
    if (push_req && full_sel) uo_d[2*int'(qsel) + 1] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (int'(region))
      RG_CFG:  if (hit) rd_mux = cfg_rd[qsel];
      RG_STAT: if (int'(idx) < NSW) rd_mux = stat_pad[int'(idx)*DW +: DW];
      RG_UO:   if (int'(idx) < NUW) rd_mux = uo_pad[int'(idx)*DW +: DW];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uo_q        <= '0;
      rvalid_q    <= 1'b0;
      from_sram_q <= 1'b0;
      rreg_q      <= '0;
    end else begin
      uo_q        <= uo_d;
      rvalid_q    <= req_i && !we_i;
      from_sram_q <= pop_ok;
      if (req_i && !we_i) rreg_q <= rd_mux;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = from_sram_q ? sram_rd : rreg_q;
endmodule

// File: rtl/shq_manager_chk.sv
module shq_manager_chk #(
  parameter int NQ = 8,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic            rvalid_o,
  input logic [DW-1:0]   rdata_o,
  input logic [4*NQ-1:0] q_status_o,
  input logic [2*NQ-1:0] uo_q
);
  localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1;

  logic acc, pop_empty, push_full, uo_wr;
  assign acc       = req_i && (addr_i[AW-1:8] == '0) && (int'(addr_i[7:0]) < NQ);
  assign pop_empty = acc && !we_i && q_status_o[4*int'(addr_i[QIW-1:0])];
  assign push_full = acc && we_i && q_status_o[4*int'(addr_i[QIW-1:0]) + 3];
  assign uo_wr     = req_i && we_i && (int'(addr_i[AW-1:8]) == 3);

  AST_READ_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R2
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_empty |=> rdata_o == '0); // R3
  AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_empty |=> uo_q[2*int'($past(addr_i[QIW-1:0]))]); // R3
  AST_OVERFLOW_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_full |=> uo_q[2*int'($past(addr_i[QIW-1:0])) + 1]); // R4

  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(q_status_o[4*q] && q_status_o[4*q+3])); // R10
    AST_EMPTY_IS_NE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_status_o[4*q] |-> q_status_o[4*q+1]); // R8
    AST_FULL_IS_NF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_status_o[4*q+3] |-> q_status_o[4*q+2]); // R9
  end

  for (genvar b = 0; b < 2*NQ; b++) begin : g_uo
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uo_q[b] && !uo_wr) |=> uo_q[b]); // R5
  end
endmodule

bind shq_manager shq_manager_chk #(.NQ(NQ), .AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .q_status_o (q_status_o),
  .uo_q       (uo_q)
);

// File: tb/shq_manager_bench.sv
`timescale 1ns/1ps
module shq_manager_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic [31:0] status;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  shq_manager u_shq_manager (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .q_status_o(status)
  );

  // {is_read, addr, wdata, expected, req tag}
  localparam int NV = 16;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 12'h101, 32'h014C0000, 32'h0,        4'd6},
    {1'b1, 12'h101, 32'h0,        32'h014C0000, 4'd6},
    {1'b0, 12'h000, 32'h000000A0, 32'h0,        4'd2},
    {1'b0, 12'h000, 32'h000000A1, 32'h0,        4'd2},
    {1'b0, 12'h001, 32'h000000B0, 32'h0,        4'd2},
    {1'b1, 12'h100, 32'h0,        32'h00000002, 4'd6},
    {1'b1, 12'h101, 32'h0,        32'h014C0001, 4'd6},
    {1'b1, 12'h000, 32'h0,        32'h000000A0, 4'd2},
    {1'b1, 12'h001, 32'h0,        32'h000000B0, 4'd2},
    {1'b1, 12'h000, 32'h0,        32'h000000A1, 4'd2},
    {1'b1, 12'h100, 32'h0,        32'h00000102, 4'd6},
    {1'b1, 12'h000, 32'h0,        32'h00000000, 4'd3},
    {1'b1, 12'h300, 32'h0,        32'h00000001, 4'd3},
    {1'b0, 12'h300, 32'hFFFFFFFE, 32'h0,        4'd5},
    {1'b1, 12'h300, 32'h0,        32'h00000000, 4'd5},
    {1'b1, 12'h200, 32'h0,        32'h33333333, 4'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rvalid ? rdata : 32'hBAD0BAD0;  // missing rvalid shows as a bad value
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h33333333);
    chk("R1 rvalid idle", {31'b0, rvalid}, 32'h0);
    rd_chk("R1 cfg q5", 12'h105, 32'h0);
    rd_chk("R1 sticky", 12'h300, 32'h0);
    @(negedge clk);
    chk("R2 rvalid one cycle", {31'b0, rvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) rd_chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][79:68], VEC[i][35:4]);
      else bus_wr(VEC[i][79:68], VEC[i][67:36]);
    end

    // R4/R7: fill q2 (base 2, 16 entries) to capacity and past it
    bus_wr(12'h102, 32'h02000000);
    bus_wr(12'h000, 32'h5A5A);
    for (int i = 0; i < 16; i++) bus_wr(12'h002, 32'h200 + i);
    chk("R7 q2 full nibble", {28'b0, status[11:8]}, 32'hC);
    bus_wr(12'h002, 32'h2FF);
    rd_chk("R4 overflow bit", 12'h300, 32'h20);
    rd_chk("R6 q2 pointers", 12'h102, 32'h02000010);
    for (int i = 0; i < 16; i++) rd_chk("R4 q2 order", 12'h002, 32'h200 + i);
    rd_chk("R7 q0 isolated", 12'h000, 32'h5A5A);
    chk("R10 q2 empty nibble", {28'b0, status[11:8]}, 32'h3);
    for (int i = 0; i < 8; i++) bus_wr(12'h002, 32'h300 + i);
    for (int i = 0; i < 8; i++) rd_chk("R7 wrap a", 12'h002, 32'h300 + i);
    for (int i = 0; i < 12; i++) bus_wr(12'h002, 32'h400 + i);
    for (int i = 0; i < 12; i++) rd_chk("R7 wrap b", 12'h002, 32'h400 + i);
    bus_wr(12'h300, 32'h0);

    // R8/R9: q3 = base 4, 32 entries, NE=4 (code 3), NF=8 (code 4)
    bus_wr(12'h103, 32'h048D0000);
    for (int k = 1; k <= 32; k++) begin
      bus_wr(12'h003, 32'h1000 + k);
      chk($sformatf("R8 ne k=%0d", k), {31'b0, status[13]}, {31'b0, k <= 4});
      chk($sformatf("R9 nf k=%0d", k), {31'b0, status[14]}, {31'b0, (32 - k) <= 8});
    end
    chk("R7 q3 full", {28'b0, status[15:12]}, 32'hC);
    rd_chk("R2 q3 head", 12'h003, 32'h1001);

    // R6/R4: 128-entry q4 at base 8
    bus_wr(12'h104, 32'h08030000);
    for (int i = 0; i < 128; i++) bus_wr(12'h004, 32'h800 + i);
    rd_chk("R6 ptr wrap equal", 12'h104, 32'h08030000);
    chk("R7 q4 full 128", {28'b0, status[19:16]}, 32'hC);
    rd_chk("R10 status word", 12'h200, 32'h333C4333);
    bus_wr(12'h004, 32'hDEAD);
    rd_chk("R4 q4 overflow", 12'h300, 32'h200);
    rd_chk("R4 q4 head kept", 12'h004, 32'h800);
    rd_chk("R6 q4 rptr", 12'h104, 32'h08030080);

    // R11: config rewrite empties the queue
    bus_wr(12'h300, 32'h0);
    bus_wr(12'h001, 32'h77);
    bus_wr(12'h101, 32'h014C0000);
    rd_chk("R11 cfg ptrs cleared", 12'h101, 32'h014C0000);
    chk("R11 q1 empty", {28'b0, status[7:4]}, 32'h3);
    rd_chk("R11 pop after reconfig", 12'h001, 32'h0);
    rd_chk("R3 q1 underflow", 12'h300, 32'h4);

    // R5: selective clear
    rd_chk("R3 q5 pop empty", 12'h005, 32'h0);
    rd_chk("R5 two bits", 12'h300, 32'h404);
    bus_wr(12'h300, 32'hFFFFFFFB);
    rd_chk("R5 one cleared", 12'h300, 32'h400);
    bus_wr(12'h300, 32'h0);
    rd_chk("R5 all cleared", 12'h300, 32'h0);

    finish_run();
  end
endmodule